// File: doc/BRIEF.md
# Asynchronous SRAM Module Controller

This controller sits between a synchronous host and an external static RAM module that is 32 bits wide, with a 19-bit word address. The module is built from four byte-wide devices. Each device owns one byte lane and has its own active-low chip select. There are no byte-enable pins, so the controller selects the lanes of an access by choosing which chip selects to pull low. All four go low for a word access, an aligned pair for a half-word, and a single one for a byte.

The host issues requests over a request/ready handshake. A request carries:
- a word address;
- a write flag;
- a size code;
- a lane offset;
- write data that is already placed on its lane positions.

The controller then runs a fixed strobe sequence on the module pins. The timing of that sequence comes from three cycle-count parameters: access length, write-pulse length, and post-write turnaround. For a read, the controller captures the selected lanes and returns them with a one-cycle valid pulse. A misaligned half-word request, or one with the reserved size code, is refused with a one-cycle error pulse and causes no pin activity.

The controller owns the module's data bus through a split output/input pair and a drive-enable. It sequences that enable against output enable so that its own drivers and the module never drive the bus in the same cycle.

Top module: `sram_ctl`

## Requirements
- R1: During and after reset, with no request pending, `ready_o` is 1, all four chip selects, write enable and output enable are high, `sram_dq_oe_o` is 0, and `rvalid_o` and `err_o` are 0.
- R2: Byte lane k carries data bits 8k+7..8k and is enabled only by chip select bit k. The size code selects the lanes as follows:
  - 0 (word): all four lanes (`sram_cs_no` = 4'b0000).
  - 1 (half): offset 0 selects lanes 0 and 1 (4'b1100); offset 2 selects lanes 2 and 3 (4'b0011).
  - 2 (byte): only lane `off_i` (bit `off_i` of `sram_cs_no` low).
- R3: A half request with offset 1 or 3, or any request with size code 3, raises `err_o` for exactly one cycle: the cycle after acceptance. Such a request drives no chip select, write enable or output enable, and `ready_o` stays 1.
- R4: A read keeps the chip selects of its lanes and output enable low for exactly ACC_CYC cycles, with write enable high and `sram_addr_o` equal to the request address. `rvalid_o` is then high for exactly one cycle, ACC_CYC+1 cycles after acceptance. At that point `rdata_o` holds the selected lanes as sampled at the end of the access, and unselected lanes read as zero.
- R5: A write drives its data with chip selects low and write enable high for one setup cycle. It then holds write enable low for exactly WP_CYC cycles, with the chip selects low and the bus driven, and the data on the module lanes is stored.
- R6: `ready_o` is high only while every strobe is high and the bus is released. After a write, at least TA_CYC+2 cycles separate the rise of write enable from the next cycle in which output enable is low.
- R7: `sram_dq_oe_o` is never high while output enable is low. It is also low in the cycle before any cycle with output enable low.
- R8: After a read, the controller drives write data no earlier than two cycles after output enable rises.
- R9: Output enable and write enable are never low in the same cycle. Write enable is low only while some chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request valid |
| ready_o | output | 1 | Controller idle; a request is accepted when req_i and ready_o are both high at a clock edge |
| addr_i | input | 19 | Word address |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | 0 word, 1 half, 2 byte, 3 reserved |
| off_i | input | 2 | Lane offset for half and byte accesses |
| wdata_i | input | 32 | Write data on lane positions |
| rvalid_o | output | 1 | One-cycle read data valid |
| rdata_o | output | 32 | Read data, unselected lanes zero |
| err_o | output | 1 | One-cycle pulse for a refused request |
| sram_addr_o | output | 19 | Module address |
| sram_cs_no | output | 4 | Per-lane chip selects, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_dq_o | output | 32 | Data driven toward the module |
| sram_dq_oe_o | output | 1 | Drive enable of the controller's data drivers |
| sram_dq_i | input | 32 | Data returned from the module |

## Verification
Request acceptance is taken as the rising edge at which `req_i` and `ready_o` are both high, and every result is timed from that edge:
- The error pulse is due one cycle later.
- Output enable is low for the next ACC_CYC cycles.
- `rvalid_o` and `rdata_o` are due ACC_CYC+1 cycles later.
- Write enable falls two cycles later and stays low for WP_CYC cycles.

The bench drives inputs and samples outputs on falling edges, counting falling edges from acceptance so that each check lands inside the cycle where the value is due. It also checks the cycle before and the cycle after each pulse. A pin monitor measures strobe widths and the gaps between write-enable rise, output-enable fall, output-enable rise and drive enable in whole cycles. These are compared with the bounds in the requirements.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [1:0] {
    SZ_WORD = 2'd0,
    SZ_HALF = 2'd1,
    SZ_BYTE = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACT,
    ST_RD_END,
    ST_WR_SET,
    ST_WR_PULSE,
    ST_WR_REC,
    ST_TURN
  } state_e;
endpackage

// File: rtl/sram_lane_dec.sv
module sram_lane_dec #(
  parameter int LANES = 4,
  localparam int OW = $clog2(LANES)
) (
  input  logic [1:0]       size_i,
  input  logic [OW-1:0]    off_i,
  output logic [LANES-1:0] lane_o,
  output logic             bad_o
);
  import sram_ctl_pkg::*;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [OW-1:0] KIDX = OW'(k);
    always_comb begin
      unique case (size_e'(size_i))
        SZ_WORD: lane_o[k] = 1'b1;
        SZ_HALF: lane_o[k] = (KIDX[OW-1:1] == off_i[OW-1:1]);
        SZ_BYTE: lane_o[k] = (KIDX == off_i);
        default: lane_o[k] = 1'b0;
      endcase
    end
  end

  assign bad_o = (size_e'(size_i) == SZ_RSVD) ||
                 ((size_e'(size_i) == SZ_HALF) && off_i[0]);
endmodule

// File: rtl/sram_seq.sv
module sram_seq #(
  parameter int ACC_CYC = 2,
  parameter int WP_CYC  = 2,
  parameter int TA_CYC  = 1,
  localparam int MAXC = (ACC_CYC > WP_CYC) ? ((ACC_CYC > TA_CYC) ? ACC_CYC : TA_CYC)
                                           : ((WP_CYC > TA_CYC) ? WP_CYC : TA_CYC),
  localparam int CW = $clog2(MAXC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic we_i,
  output logic ready_o,
  output logic cs_act_o,
  output logic oe_act_o,
  output logic we_act_o,
  output logic drive_o,
  output logic cap_o
);
  import sram_ctl_pkg::*;

  state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic last;

  assign last = (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = last ? cnt_q : cnt_q - 1'b1;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d  = we_i ? ST_WR_SET : ST_RD_ACT;
        cnt_d = CW'(ACC_CYC - 1);
      end
      ST_RD_ACT:   if (last) st_d = ST_RD_END;
      ST_RD_END:   st_d = ST_IDLE;
      ST_WR_SET: begin
        st_d  = ST_WR_PULSE;
        cnt_d = CW'(WP_CYC - 1);
      end
      ST_WR_PULSE: if (last) st_d = ST_WR_REC;
      ST_WR_REC: begin
        st_d  = (TA_CYC == 0) ? ST_IDLE : ST_TURN;
        cnt_d = CW'((TA_CYC > 0) ? TA_CYC - 1 : 0);
      end
      ST_TURN:     if (last) st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign ready_o  = (st_q == ST_IDLE);
  assign cs_act_o = (st_q == ST_RD_ACT) || (st_q == ST_WR_SET) || (st_q == ST_WR_PULSE);
  assign oe_act_o = (st_q == ST_RD_ACT);
  assign we_act_o = (st_q == ST_WR_PULSE);
  assign drive_o  = (st_q == ST_WR_SET) || (st_q == ST_WR_PULSE) || (st_q == ST_WR_REC);
  assign cap_o    = (st_q == ST_RD_ACT) && last;
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int AW      = 19,
  parameter int LANES   = 4,
  parameter int ACC_CYC = 2,
  parameter int WP_CYC  = 2,
  parameter int TA_CYC  = 1,
  localparam int DW = 8 * LANES,
  localparam int OW = $clog2(LANES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  output logic          ready_o,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [1:0]    size_i,
  input  logic [OW-1:0] off_i,
  input  logic [DW-1:0] wdata_i,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o,
  output logic          err_o,
  output logic [AW-1:0] sram_addr_o,
  output logic [LANES-1:0] sram_cs_no,
  output logic          sram_we_no,
  output logic          sram_oe_no,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe_o,
  input  logic [DW-1:0] sram_dq_i
);
  logic [LANES-1:0] lane_d, lane_q;
  logic [DW-1:0]    lane_bits;
  logic bad, accept, start;
  logic cs_act, oe_act, we_act, drive, cap;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic rvalid_q, err_q;

  sram_lane_dec #(.LANES(LANES)) u_dec (
    .size_i (size_i),
    .off_i  (off_i),
    .lane_o (lane_d),
    .bad_o  (bad)
  );

  assign accept = req_i && ready_o;
  assign start  = accept && !bad;

  sram_seq #(.ACC_CYC(ACC_CYC), .WP_CYC(WP_CYC), .TA_CYC(TA_CYC)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .we_i     (we_i),
    .ready_o  (ready_o),
    .cs_act_o (cs_act),
    .oe_act_o (oe_act),
    .we_act_o (we_act),
    .drive_o  (drive),
    .cap_o    (cap)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_mask
    assign lane_bits[8*k +: 8] = {8{lane_q[k]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      lane_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (start) begin
        addr_q  <= addr_i;
        lane_q  <= lane_d;
        wdata_q <= wdata_i;
      end
      if (cap) rdata_q <= sram_dq_i & lane_bits;
      rvalid_q <= cap;
      err_q    <= accept && bad;
    end
  end

  assign sram_addr_o  = addr_q;
  assign sram_cs_no   = cs_act ? ~lane_q : '1;
  assign sram_oe_no   = !oe_act;
  assign sram_we_no   = !we_act;
  assign sram_dq_o    = wdata_q;
  assign sram_dq_oe_o = drive;
  assign rvalid_o     = rvalid_q;
  assign rdata_o      = rdata_q;
  assign err_o        = err_q;
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int WP_CYC = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ready_o,
  input logic       rvalid_o,
  input logic       err_o,
  input logic [3:0] sram_cs_no,
  input logic       sram_we_no,
  input logic       sram_oe_no,
  input logic       sram_dq_oe_o
);
  logic [3:0] lanes;
  logic [15:0] wlow;

  assign lanes = ~sram_cs_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wlow <= '0;
    else if (!sram_we_no) wlow <= wlow + 1'b1;
    else wlow <= '0;
  end

  assert_legal_lanes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lanes != 4'h0) |-> (lanes == 4'hF || lanes == 4'h3 || lanes == 4'hC || $onehot(lanes)));

  assert_err_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (sram_cs_no == 4'hF && ready_o && sram_we_no && sram_oe_no));

  assert_rvalid_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  assert_wp_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (wlow == 16'(WP_CYC)));

  assert_we_driven_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> sram_dq_oe_o);

  assert_ready_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sram_cs_no == 4'hF && sram_we_no && sram_oe_no && !sram_dq_oe_o));

  assert_no_contention_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_no |-> (!sram_dq_oe_o && !$past(sram_dq_oe_o)));

  assert_strobe_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (sram_oe_no && sram_cs_no != 4'hF));
endmodule

bind sram_ctl sram_ctl_chk #(.WP_CYC(WP_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ready_o      (ready_o),
  .rvalid_o     (rvalid_o),
  .err_o        (err_o),
  .sram_cs_no   (sram_cs_no),
  .sram_we_no   (sram_we_no),
  .sram_oe_no   (sram_oe_no),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;
  localparam int ACC = 2;
  localparam int WP  = 2;
  localparam int TA  = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [18:0] addr = '0;
  logic [1:0] size = '0, off = '0;
  logic [31:0] wdata = '0;
  logic ready, rvalid, err;
  logic [31:0] rdata;
  logic [18:0] s_addr;
  logic [3:0] s_cs_n;
  logic s_we_n, s_oe_n, s_dq_oe;
  logic [31:0] s_dq_o, s_dq_i;

  always #2.5 clk = ~clk;

  sram_ctl #(.ACC_CYC(ACC), .WP_CYC(WP), .TA_CYC(TA)) u_sram_ctl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ready_o(ready),
    .addr_i(addr), .we_i(we), .size_i(size), .off_i(off), .wdata_i(wdata),
    .rvalid_o(rvalid), .rdata_o(rdata), .err_o(err),
    .sram_addr_o(s_addr), .sram_cs_no(s_cs_n), .sram_we_no(s_we_n),
    .sram_oe_no(s_oe_n), .sram_dq_o(s_dq_o), .sram_dq_oe_o(s_dq_oe),
    .sram_dq_i(s_dq_i)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem [4][64];
  logic [7:0] exp_mem [4][64];
  logic [18:0] cur_addr = '0;
  logic [3:0] cur_mask = '0;

  task automatic chk(input bit ok, input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req_tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_lanes(input logic [1:0] sz, input logic [1:0] of, output bit bad);
    bad = (sz == 2'd3) || (sz == 2'd1 && of[0]);
    case (sz)
      2'd0: return 4'hF;
      2'd1: return of[1] ? 4'hC : 4'h3;
      2'd2: return 4'(1 << of);
      default: return 4'h0;
    endcase
  endfunction

  // module model: lanes answer only when selected, output enabled and not writing
  always_comb begin
    for (int k = 0; k < 4; k++)
      s_dq_i[8*k +: 8] = (!s_cs_n[k] && !s_oe_n && s_we_n) ? mem[k][s_addr[5:0]] : 8'hEE;
  end

  // pin monitor
  int cyc = 0, we_low = 0, oe_low = 0;
  int we_rise = -1000, oe_rise = -1000;
  logic p_we_n = 1'b1, p_oe_n = 1'b1, p_dq_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!s_we_n) begin
        for (int k = 0; k < 4; k++)
          if (!s_cs_n[k] && s_dq_oe) mem[k][s_addr[5:0]] = s_dq_o[8*k +: 8];
        we_low++;
        chk(s_oe_n && s_dq_oe, "R9", {30'd0, s_oe_n, s_dq_oe}, 32'd3);
      end else if (!p_we_n) begin
        chk(we_low == WP, "R5", we_low, WP);
        we_low = 0;
        we_rise = cyc;
      end
      if (s_cs_n != 4'hF) begin
        chk(~s_cs_n == cur_mask, "R2", {28'd0, ~s_cs_n}, {28'd0, cur_mask});
        chk(s_addr == cur_addr, "R4", {13'd0, s_addr}, {13'd0, cur_addr});
      end
      if (!s_oe_n) begin
        oe_low++;
        chk(!s_dq_oe && !p_dq_oe, "R7", {30'd0, s_dq_oe, p_dq_oe}, 32'd0);
        if (p_oe_n) chk(cyc - we_rise >= TA + 2, "R6", cyc - we_rise, TA + 2);
      end else if (!p_oe_n) begin
        chk(oe_low == ACC, "R4", oe_low, ACC);
        oe_low = 0;
        oe_rise = cyc;
      end
      if (s_dq_oe && !p_dq_oe) chk(cyc - oe_rise >= 2, "R8", cyc - oe_rise, 2);
      p_we_n = s_we_n; p_oe_n = s_oe_n; p_dq_oe = s_dq_oe;
    end
  end

  task automatic do_req(input logic [18:0] a, input logic w, input logic [1:0] sz,
                        input logic [1:0] of, input logic [31:0] d);
    bit bad;
    logic [3:0] m;
    logic [31:0] exp_rd;
    m = exp_lanes(sz, of, bad);
    while (!ready) @(negedge clk);
    req = 1'b1; addr = a; we = w; size = sz; off = of; wdata = d;
    if (!bad) begin cur_addr = a; cur_mask = m; end
    @(negedge clk);
    req = 1'b0;
    if (bad) begin
      chk(err == 1'b1, "R3", {31'd0, err}, 1);
      chk(s_cs_n == 4'hF && s_we_n && s_oe_n && ready, "R3", {27'd0, s_cs_n, s_we_n}, 32'h1F);
      @(negedge clk);
      chk(err == 1'b0, "R3", {31'd0, err}, 0);
    end else if (!w) begin
      exp_rd = '0;
      for (int k = 0; k < 4; k++) if (m[k]) exp_rd[8*k +: 8] = exp_mem[k][a[5:0]];
      repeat (ACC - 1) @(negedge clk);
      chk(rvalid == 1'b0, "R4", {31'd0, rvalid}, 0);
      @(negedge clk);
      chk(rvalid == 1'b1, "R4", {31'd0, rvalid}, 1);
      chk(rdata == exp_rd, "R4", rdata, exp_rd);
      @(negedge clk);
      chk(rvalid == 1'b0, "R4", {31'd0, rvalid}, 0);
    end else begin
      for (int k = 0; k < 4; k++) if (m[k]) exp_mem[k][a[5:0]] = d[8*k +: 8];
      chk(s_cs_n == ~m && s_we_n && s_dq_oe && s_dq_o == d, "R5", {27'd0, s_cs_n, s_we_n}, {27'd0, ~m, 1'b1});
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 64; a++) begin
        mem[k][a] = 8'((k * 64 + a) ^ 8'h5A);
        exp_mem[k][a] = mem[k][a];
      end
    repeat (3) @(negedge clk);
    chk(ready && s_cs_n == 4'hF && s_we_n && s_oe_n && !s_dq_oe && !rvalid && !err,
        "R1", {26'd0, ready, s_cs_n, s_dq_oe}, {26'd0, 1'b1, 4'hF, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && s_cs_n == 4'hF && !s_dq_oe, "R1", {27'd0, ready, s_cs_n}, 32'h1F);

    do_req(19'h00005, 1'b1, 2'd0, 2'd0, 32'hA1B2C3D4);
    do_req(19'h00005, 1'b0, 2'd0, 2'd0, 32'h0);
    do_req(19'h00007, 1'b1, 2'd1, 2'd0, 32'h11223344);
    do_req(19'h00007, 1'b1, 2'd1, 2'd2, 32'h55667788);
    do_req(19'h00007, 1'b0, 2'd0, 2'd0, 32'h0);
    do_req(19'h00007, 1'b0, 2'd1, 2'd2, 32'h0);
    for (int o = 0; o < 4; o++) begin
      do_req(19'h40009, 1'b1, 2'd2, 2'(o), 32'(32'h10203040 + o));
      do_req(19'h40009, 1'b0, 2'd2, 2'(o), 32'h0);
    end
    do_req(19'h00003, 1'b1, 2'd1, 2'd1, 32'hDEADBEEF);
    do_req(19'h00003, 1'b0, 2'd1, 2'd3, 32'h0);
    do_req(19'h00003, 1'b1, 2'd3, 2'd0, 32'hDEADBEEF);
    do_req(19'h00003, 1'b0, 2'd0, 2'd0, 32'h0);

    for (int i = 0; i < 400; i++)
      do_req(19'($urandom), 1'($urandom), 2'($urandom), 2'($urandom), $urandom);
    for (int a = 0; a < 64; a++)
      do_req(19'(a), 1'b0, 2'd0, 2'd0, 32'h0);
    repeat (4) @(negedge clk);
    report();
  end
endmodule